// File: doc/BRIEF.md
# Ethernet Pause Flow Controller

This block sits beside an Ethernet MAC and carries out IEEE 802.3 Pause flow control. At the end of every received frame the receive path shows the parsed header fields to the block, together with the frame byte count, the CRC verdict and the address-match verdict. The block then issues exactly one outcome strobe: forward the frame to the host, drop it, or consume it as a Pause request. A consumed request loads a local pause timer. While that timer is nonzero the block holds the transmitter, but only from a gap between frames.

A second timer estimates how long the link partner stays silent after this station sends its own Pause frame. Both timers count down once per pause quantum (512 bit times), using a tick supplied by the MAC. Control inputs select the following:
- whether control handling is on at all;
- whether short or long control frames reach the host;
- whether valid Pause frames are acted on internally or handed to software;
- whether control frames are still examined while the local timer runs.

A sticky flag records that a nonzero pause was accepted. Software clears it by writing a 1.

Top module: `pause_flow_ctrl`

## Requirements
- R1: When control handling is disabled, or the length/type field is not 0x8808, the frame is forwarded (rx_fwd_o) and the local timer is unchanged.
- R2: A frame of type 0x8808 without an address match is dropped (rx_drop_o) with no timer change.
- R3: A control frame whose byte count including CRC is not 64 is never acted on. It is forwarded when pass-through is on and dropped otherwise.
- R4: A 64-byte, address-matched control frame with a bad CRC, or with an opcode other than 0x0001, is dropped with no timer change.
- R5: A frame passing all five checks is consumed (rx_pause_o), and the local timer takes the 16-bit operand. In software mode the frame is instead forwarded and the timer is not loaded. All outcome strobes appear one cycle after rx_eof_i.
- R6: The local timer decreases by one per quantum tick and stops at zero. An accepted frame reloads it even while it is running. An operand of zero clears it. A load in the same cycle as a tick takes the operand value.
- R7: tx_hold_o rises only in a cycle after tx_busy_i was low while the timer was nonzero. Once high, it stays high until the timer is zero, and it falls one cycle after the timer reaches zero.
- R8: While the local timer is nonzero and the detect-while-paused control is clear, every address-matched control frame is dropped without effect. When that control is set, such frames are processed normally.
- R9: pause_seen_o sets when a frame with a nonzero operand is consumed. A 1 on pause_seen_clr_i clears it. If both happen in the same cycle, the set wins.
- R10: A tx_pause_sent_i pulse loads the remote timer with tx_pause_time_i, and the load wins over a tick in the same cycle. The remote timer then counts down per tick to zero. remote_paused_o is high exactly while the remote timer is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_eof_i | input | 1 | End-of-frame strobe; header fields and verdicts valid |
| rx_type_i | input | 16 | Length/type field |
| rx_opcode_i | input | 16 | Control opcode field |
| rx_operand_i | input | 16 | Pause time operand in quanta |
| rx_len_i | input | 11 | Frame byte count including CRC |
| rx_crc_ok_i | input | 1 | CRC check passed |
| rx_addr_hit_i | input | 1 | Destination address recognised |
| ctl_en_i | input | 1 | Enable MAC control handling |
| pass_thru_i | input | 1 | Forward control frames that fail the length check |
| sw_mode_i | input | 1 | Hand valid Pause frames to software |
| detect_in_pause_i | input | 1 | Examine control frames while paused |
| quanta_tick_i | input | 1 | One pulse per pause quantum |
| tx_busy_i | input | 1 | Transmitter is sending a frame |
| tx_pause_sent_i | input | 1 | This station sent a Pause frame |
| tx_pause_time_i | input | 16 | Operand of the sent Pause frame |
| pause_seen_clr_i | input | 1 | Write-1 clear of pause_seen_o |
| rx_fwd_o | output | 1 | Frame goes to the host |
| rx_drop_o | output | 1 | Frame discarded |
| rx_pause_o | output | 1 | Frame consumed as Pause request |
| tx_hold_o | output | 1 | Hold transmitter |
| local_timer_o | output | 16 | Local pause timer |
| remote_timer_o | output | 16 | Remote pause estimate |
| remote_paused_o | output | 1 | Partner assumed paused |
| pause_seen_o | output | 1 | Sticky: nonzero pause accepted |

## Verification
Three pairs of events can land on the same clock edge:
- a Pause frame acceptance and a quantum tick, which both update the local timer;
- a sent-Pause load and a tick, on the remote timer;
- a sticky set and a software clear.

The bench drives each pair in the same cycle on purpose. It then checks that the load value, or the set, is what survives, and compares against values worked out from the operand rather than from a decrement. A full sweep over all 256 combinations of the five validity checks and three mode bits judges the outcome ordering against a reference decision computed in the bench.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_FWD   = 2'd1,
    RES_DROP  = 2'd2,
    RES_PAUSE = 2'd3
  } rx_res_e;
endpackage

// File: rtl/pfc_classify.sv
module pfc_classify
  import pfc_pkg::*;
#(
  parameter int TIME_W    = 16,
  parameter int LEN_W     = 11,
  parameter int FRAME_LEN = 64,
  parameter logic [15:0] CTRL_TYPE = 16'h8808,
  parameter logic [15:0] PAUSE_OP  = 16'h0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eof_i,
  input  logic [15:0]       type_i,
  input  logic [15:0]       opcode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              crc_ok_i,
  input  logic              addr_hit_i,
  input  logic              ctl_en_i,
  input  logic              pass_thru_i,
  input  logic              sw_mode_i,
  input  logic              detect_in_pause_i,
  input  logic              timer_busy_i,
  output logic              load_o,
  output rx_res_e           res_o
);
  localparam logic [LEN_W-1:0] LenExp = LEN_W'(FRAME_LEN);

  rx_res_e res_d, res_q;

  // check order sets which outcome a frame failing several checks gets
  always_comb begin
    res_d = RES_NONE;
    if (eof_i) begin
      if (!ctl_en_i || type_i != CTRL_TYPE)          res_d = RES_FWD;
      else if (!addr_hit_i)                          res_d = RES_DROP;
      else if (timer_busy_i && !detect_in_pause_i)   res_d = RES_DROP;
      else if (len_i != LenExp)                      res_d = pass_thru_i ? RES_FWD : RES_DROP;
      else if (!crc_ok_i || opcode_i != PAUSE_OP)    res_d = RES_DROP;
      else if (sw_mode_i)                            res_d = RES_FWD;
      else                                           res_d = RES_PAUSE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= RES_NONE;
    else         res_q <= res_d;
  end

  assign load_o = (res_d == RES_PAUSE);
  assign res_o  = res_q;
endmodule

// File: rtl/pfc_timer.sv
module pfc_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int TIME_W    = 16,
  parameter int LEN_W     = 11,
  parameter int FRAME_LEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_eof_i,
  input  logic [15:0]       rx_type_i,
  input  logic [15:0]       rx_opcode_i,
  input  logic [TIME_W-1:0] rx_operand_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic              rx_crc_ok_i,
  input  logic              rx_addr_hit_i,
  input  logic              ctl_en_i,
  input  logic              pass_thru_i,
  input  logic              sw_mode_i,
  input  logic              detect_in_pause_i,
  input  logic              quanta_tick_i,
  input  logic              tx_busy_i,
  input  logic              tx_pause_sent_i,
  input  logic [TIME_W-1:0] tx_pause_time_i,
  input  logic              pause_seen_clr_i,
  output logic              rx_fwd_o,
  output logic              rx_drop_o,
  output logic              rx_pause_o,
  output logic              tx_hold_o,
  output logic [TIME_W-1:0] local_timer_o,
  output logic [TIME_W-1:0] remote_timer_o,
  output logic              remote_paused_o,
  output logic              pause_seen_o
);
  rx_res_e res;
  logic    load;
  logic    hold_q, seen_q;
  logic    local_busy;

  assign local_busy = (local_timer_o != '0);

  pfc_classify #(
    .TIME_W(TIME_W), .LEN_W(LEN_W), .FRAME_LEN(FRAME_LEN)
  ) u_cls (
    .clk_i, .rst_ni,
    .eof_i(rx_eof_i), .type_i(rx_type_i), .opcode_i(rx_opcode_i),
    .len_i(rx_len_i), .crc_ok_i(rx_crc_ok_i), .addr_hit_i(rx_addr_hit_i),
    .ctl_en_i, .pass_thru_i, .sw_mode_i, .detect_in_pause_i,
    .timer_busy_i(local_busy), .load_o(load), .res_o(res)
  );

  pfc_timer #(.W(TIME_W)) u_local (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(rx_operand_i),
    .tick_i(quanta_tick_i), .count_o(local_timer_o)
  );

  pfc_timer #(.W(TIME_W)) u_remote (
    .clk_i, .rst_ni, .load_i(tx_pause_sent_i), .load_val_i(tx_pause_time_i),
    .tick_i(quanta_tick_i), .count_o(remote_timer_o)
  );

  // hold engages only in an inter-frame gap, then sticks until timer drains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      hold_q <= local_busy && (hold_q || !tx_busy_i);
      if (load && rx_operand_i != '0) seen_q <= 1'b1;
      else if (pause_seen_clr_i)      seen_q <= 1'b0;
    end
  end

  assign rx_fwd_o        = (res == RES_FWD);
  assign rx_drop_o       = (res == RES_DROP);
  assign rx_pause_o      = (res == RES_PAUSE);
  assign tx_hold_o       = hold_q;
  assign remote_paused_o = (remote_timer_o != '0);
  assign pause_seen_o    = seen_q;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int TIME_W = 16,
  parameter int LEN_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_eof_i,
  input logic [15:0]       rx_type_i,
  input logic [TIME_W-1:0] rx_operand_i,
  input logic [LEN_W-1:0]  rx_len_i,
  input logic              rx_crc_ok_i,
  input logic              rx_addr_hit_i,
  input logic              quanta_tick_i,
  input logic              tx_busy_i,
  input logic              tx_pause_sent_i,
  input logic [TIME_W-1:0] tx_pause_time_i,
  input logic              pause_seen_clr_i,
  input logic              rx_fwd_o,
  input logic              rx_drop_o,
  input logic              rx_pause_o,
  input logic              tx_hold_o,
  input logic [TIME_W-1:0] local_timer_o,
  input logic [TIME_W-1:0] remote_timer_o,
  input logic              pause_seen_o
);
  AST_OUTCOME_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_fwd_o || rx_drop_o || rx_pause_o) |-> $past(rx_eof_i)); // R1
  AST_PAUSE_NEEDS_CHECKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pause_o |-> ($past(rx_type_i) == 16'h8808 && $past(rx_len_i) == LEN_W'(64)
                    && $past(rx_crc_ok_i) && $past(rx_addr_hit_i))); // R5
  AST_PAUSE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pause_o |-> local_timer_o == $past(rx_operand_i)); // R6
  AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_pause_o && $past(quanta_tick_i) && $past(local_timer_o) != '0)
      |-> local_timer_o == $past(local_timer_o) - 1'b1); // R6
  AST_HOLD_IN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_hold_o) |-> !$past(tx_busy_i)); // R7
  AST_HOLD_NEEDS_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_hold_o |-> $past(local_timer_o) != '0); // R7
  AST_SEEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pause_seen_clr_i) && !rx_pause_o) |-> !pause_seen_o); // R9
  AST_REMOTE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tx_pause_sent_i) |-> remote_timer_o == $past(tx_pause_time_i)); // R10
endmodule

bind pause_flow_ctrl pfc_checker #(.TIME_W(TIME_W), .LEN_W(LEN_W)) u_pfc_chk (.*);

// File: tb/tb_pause_flow_ctrl.sv
module tb_pause_flow_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_eof_i = 0, rx_crc_ok_i = 0, rx_addr_hit_i = 0;
  logic [15:0] rx_type_i = 0, rx_opcode_i = 0, rx_operand_i = 0, tx_pause_time_i = 0;
  logic [10:0] rx_len_i = 0;
  logic ctl_en_i = 0, pass_thru_i = 0, sw_mode_i = 0, detect_in_pause_i = 1;
  logic quanta_tick_i = 0, tx_busy_i = 0, tx_pause_sent_i = 0, pause_seen_clr_i = 0;
  logic rx_fwd_o, rx_drop_o, rx_pause_o, tx_hold_o, remote_paused_o, pause_seen_o;
  logic [15:0] local_timer_o, remote_timer_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  pause_flow_ctrl dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // outcome code: 1 fwd, 2 drop, 3 pause
  function automatic int ref_res(bit t, bit a, bit busy, bit det, bit l, bit c, bit o,
                                 bit p, bit en, bit sw);
    if (!en || !t) return 1;
    if (!a) return 2;
    if (busy && !det) return 2;
    if (!l) return p ? 1 : 2;
    if (!c || !o) return 2;
    return sw ? 1 : 3;
  endfunction

  function automatic int got_res();
    return rx_pause_o ? 3 : rx_drop_o ? 2 : rx_fwd_o ? 1 : 0;
  endfunction

  task automatic send(input bit t, a, l, c, o, input logic [15:0] opnd, input bit tick,
                      input bit odd_len);
    @(negedge clk_i);
    rx_eof_i = 1; rx_type_i = t ? 16'h8808 : 16'h0800; rx_addr_hit_i = a;
    rx_len_i = l ? 11'd64 : (odd_len ? 11'd63 : 11'd65); rx_crc_ok_i = c;
    rx_opcode_i = o ? 16'h0001 : 16'h0002; rx_operand_i = opnd; quanta_tick_i = tick;
    @(negedge clk_i);
    rx_eof_i = 0; quanta_tick_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); quanta_tick_i = 1;
      @(negedge clk_i); quanta_tick_i = 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #35 rst_ni = 1;
    @(negedge clk_i);
    chk(got_res() == 0 && local_timer_o == 0 && !tx_hold_o && !pause_seen_o
        && remote_timer_o == 0, "reset", got_res(), 0);

    // R1 R2 R3 R4 R5 full sweep of checks and mode bits, timer idle
    for (int i = 0; i < 256; i++) begin
      int e;
      ctl_en_i = i[5]; pass_thru_i = i[6]; sw_mode_i = i[7];
      e = ref_res(i[0], i[1], 0, 1, i[2], i[3], i[4], i[6], i[5], i[7]);
      send(i[0], i[1], i[2], i[3], i[4], 16'd3, 0, i[8]);
      chk(got_res() == e, "R1 R2 R3 R4 R5 outcome", got_res(), e);
      chk(local_timer_o == ((e == 3) ? 3 : 0), "R5 timer load", local_timer_o, (e == 3) ? 3 : 0);
      if (e == 3) begin
        ticks(3);
        chk(local_timer_o == 0, "R6 drain", local_timer_o, 0);
      end
    end
    ctl_en_i = 1; pass_thru_i = 0; sw_mode_i = 0;

    // R9 sticky clear, then zero operand does not set
    @(negedge clk_i); pause_seen_clr_i = 1;
    @(negedge clk_i); pause_seen_clr_i = 0;
    chk(!pause_seen_o, "R9 clear", pause_seen_o, 0);
    send(1, 1, 1, 1, 1, 16'd0, 0, 0);
    chk(!pause_seen_o && local_timer_o == 0, "R9 zero operand", pause_seen_o, 0);

    // R7 hold waits for gap
    tx_busy_i = 1;
    send(1, 1, 1, 1, 1, 16'd5, 0, 0);
    chk(pause_seen_o, "R9 set", pause_seen_o, 1);
    repeat (3) @(negedge clk_i);
    chk(!tx_hold_o, "R7 busy blocks hold", tx_hold_o, 0);
    tx_busy_i = 0;
    @(negedge clk_i);
    chk(tx_hold_o, "R7 hold in gap", tx_hold_o, 1);
    tx_busy_i = 1;
    @(negedge clk_i);
    chk(tx_hold_o, "R7 hold sticks", tx_hold_o, 1);
    tx_busy_i = 0;
    ticks(4);
    chk(local_timer_o == 1 && tx_hold_o, "R6 count", local_timer_o, 1);
    ticks(1);
    chk(local_timer_o == 0 && tx_hold_o, "R7 hold lag", tx_hold_o, 1);
    @(negedge clk_i);
    chk(!tx_hold_o, "R7 hold release", tx_hold_o, 0);
    ticks(2);
    chk(local_timer_o == 0, "R6 stop at zero", local_timer_o, 0);

    // R8 detect-while-paused control
    send(1, 1, 1, 1, 1, 16'd10, 0, 0);
    detect_in_pause_i = 0;
    send(1, 1, 1, 1, 1, 16'd2, 0, 0);
    chk(rx_drop_o && local_timer_o == 10, "R8 ignored while paused", local_timer_o, 10);
    detect_in_pause_i = 1;
    send(1, 1, 1, 1, 1, 16'd2, 0, 0);
    chk(rx_pause_o && local_timer_o == 2, "R6 R8 reload running", local_timer_o, 2);
    send(1, 1, 1, 1, 1, 16'd0, 0, 0);
    chk(local_timer_o == 0, "R6 zero clears", local_timer_o, 0);
    send(1, 1, 1, 1, 1, 16'd7, 1, 0);
    chk(local_timer_o == 7, "R6 load beats tick", local_timer_o, 7);

    // R9 set and clear same cycle
    @(negedge clk_i); pause_seen_clr_i = 1;
    @(negedge clk_i); pause_seen_clr_i = 0;
    @(negedge clk_i);
    rx_eof_i = 1; rx_type_i = 16'h8808; rx_addr_hit_i = 1; rx_len_i = 11'd64;
    rx_crc_ok_i = 1; rx_opcode_i = 16'h0001; rx_operand_i = 16'd4; pause_seen_clr_i = 1;
    @(negedge clk_i); rx_eof_i = 0; pause_seen_clr_i = 0;
    chk(pause_seen_o, "R9 set wins", pause_seen_o, 1);

    // R10 remote timer
    @(negedge clk_i); tx_pause_sent_i = 1; tx_pause_time_i = 16'd4; quanta_tick_i = 1;
    @(negedge clk_i); tx_pause_sent_i = 0; quanta_tick_i = 0;
    chk(remote_timer_o == 4 && remote_paused_o, "R10 load", remote_timer_o, 4);
    ticks(3);
    chk(remote_timer_o == 1 && remote_paused_o, "R10 count", remote_timer_o, 1);
    ticks(1);
    chk(remote_timer_o == 0 && !remote_paused_o, "R10 expire", remote_timer_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule